// File: doc/BRIEF.md
# Burst Gating and Resync Controller

This block decides which received bits take part in the error count of a bit-error analyzer. It takes one bit per clock when `bit_valid` is high, together with that bit's error flag and a gate level. It produces a per-bit count enable, a resync pulse for the pattern synchronizer, a saturating error count, and a sticky timing-violation flag.

The block has two modes. In continuous-gated mode a high gate removes bits from the count. The gate is sampled once per block of `BLOCK_BITS` valid bits, so every excluded stretch is a whole number of blocks.

In burst mode a low gate marks a burst and a high gate marks the gap between bursts. An accepted burst starts with a resync request, followed by a settling window in which no bits are counted. The window length depends on whether the pattern comes from a hardware sequence generator or from pattern memory. Errors counted during a burst are held aside, and they reach the count only if the burst was long enough. A burst that starts too soon after a short gate pulse, or before the backlash guard has elapsed, is refused and flagged.

Top module: `bgr_controller`

## Requirements
- R1: After reset, `count_en` and `resync` are low, `err_count` is zero and `timing_viol` is low.
- R2: In gated mode (`burst_mode`=0), a block position counts valid bits from reset modulo `BLOCK_BITS`. The gate level seen on the first valid bit of a block (position 0) applies to every bit of that block. A valid bit is counted when its block's gate is low, and `count_en` is high in the clock after each counted bit.
- R3: A counted bit with `bit_err`=1 raises `err_count` by one, visible in the clock after the bit. An error on a bit that is not counted never changes `err_count`.
- R4: `err_count` saturates at 2^`CNT_W`-1 and never wraps.
- R5: `clr` is synchronous. It zeroes `err_count`, the pending burst errors and `timing_viol`, and it takes precedence over any increment in the same clock.
- R6: In burst mode, a gate sampled low while waiting starts a burst. The burst is accepted only if the gate was high for at least `MIN_GATE_CLKS` clocks and at least `BACKLASH_BITS` valid bits arrived since the gate rose; both conditions count as met after reset. An accepted burst raises `resync` for exactly one clock, in the clock after its first valid bit.
- R7: In an accepted burst, the first `PRBS_SYNC_BLOCKS`·`BLOCK_BITS` valid bits (`mem_pattern`=0) or the first `MEM_SYNC_BLOCKS`·`BLOCK_BITS` valid bits (`mem_pattern`=1) are not counted. Later valid bits are counted while the gate stays low. Bits sampled with the gate high are never counted in burst mode.
- R8: Errors counted in a burst are held pending. They are added to `err_count`, with saturation, at the clock where the gate is sampled high, provided the burst held at least `MIN_BURST_BITS` valid bits.
- R9: A burst that ends with fewer than `MIN_BURST_BITS` valid bits discards its pending errors and sets `timing_viol`.
- R10: A burst start that fails either condition of R6 is refused. It sets `timing_viol`, issues no resync and counts nothing until the gate has gone high again.
- R11: Once set, `timing_viol` stays high until `clr` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of count, pending errors and violation flag |
| burst_mode | input | 1 | 0: continuous-gated, 1: burst; hold steady outside reset |
| mem_pattern | input | 1 | 0: generated sequence, 1: memory pattern (selects settling window) |
| gate | input | 1 | Gate level; high excludes bits / separates bursts |
| bit_valid | input | 1 | A received bit is present this clock |
| bit_err | input | 1 | The present bit is in error |
| count_en | output | 1 | The bit of the previous clock was counted |
| resync | output | 1 | One-clock resync request to the pattern synchronizer |
| err_count | output | CNT_W | Saturating count of counted errored bits |
| timing_viol | output | 1 | Sticky gate-timing violation |

## Verification
The bench builds the block with `BLOCK_BITS`=8, settling windows of 3 and 5 blocks, `BACKLASH_BITS`=20, `MIN_BURST_BITS`=60, `MIN_GATE_CLKS`=6 and `CNT_W`=6. With these values, block alignment, both settling windows, short bursts, short gate pulses and the backlash guard each take only tens of clocks to reach. The 6-bit counter can also be driven into saturation, both by direct increments and by a burst commit.

// File: rtl/bgr_pkg.sv
// Shared types for the burst gating and resync controller.
package bgr_pkg;
    // Burst-mode phase: waiting in a gap, settling, counting, or refused burst.
    typedef enum logic [1:0] {
        PH_GAP   = 2'd0,
        PH_SYNC  = 2'd1,
        PH_COUNT = 2'd2,
        PH_REJ   = 2'd3
    } phase_t;
endpackage

// File: rtl/bgr_block_quant.sv
// Block quantizer: tracks position of valid bits inside BLOCK_BITS-bit
// blocks and latches the gate level at each block's first bit.
// Assumes BLOCK_BITS is a power of two of at least 2.
module bgr_block_quant #(
    parameter int BLOCK_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic bit_valid,
    output logic gate_eff
);
    localparam int POS_W = $clog2(BLOCK_BITS);
    localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_BITS - 1);

    logic [POS_W-1:0] pos_q;
    logic             blk_gate_q;

    // Gate applied to the current bit: live at block start, latched otherwise.
    always_comb gate_eff = (pos_q == '0) ? gate : blk_gate_q;

    // Advance block position and capture the gate at each block boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            blk_gate_q <= 1'b0;
        end else if (bit_valid) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + POS_W'(1);
            if (pos_q == '0) blk_gate_q <= gate;
        end
    end
endmodule

// File: rtl/bgr_burst_fsm.sv
// Burst phase machine: checks gate timing at each burst start, runs the
// settling window, and flags burst end with commit or short-burst status.
// Assumes all limits are at least 1 and mode inputs change only in reset.
module bgr_burst_fsm
    import bgr_pkg::*;
#(
    parameter int BLOCK_BITS       = 512,
    parameter int PRBS_SYNC_BLOCKS = 3,
    parameter int MEM_SYNC_BLOCKS  = 30,
    parameter int BACKLASH_BITS    = 1536,
    parameter int MIN_BURST_BITS   = 2560,
    parameter int MIN_GATE_CLKS    = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mem_pattern,
    input  logic gate,
    input  logic bit_valid,
    output logic count_now,
    output logic resync_now,
    output logic commit,
    output logic short_end,
    output logic reject_now,
    output logic pend_clr
);
    localparam int PRBS_BITS = PRBS_SYNC_BLOCKS * BLOCK_BITS;
    localparam int MEM_BITS  = MEM_SYNC_BLOCKS * BLOCK_BITS;
    localparam int SYNC_MAX  = (PRBS_BITS > MEM_BITS) ? PRBS_BITS : MEM_BITS;
    localparam int SYNC_W    = $clog2(SYNC_MAX + 1);
    localparam int HI_W      = $clog2(MIN_GATE_CLKS + 1);
    localparam int GAP_W     = $clog2(BACKLASH_BITS + 1);
    localparam int BB_W      = $clog2(MIN_BURST_BITS + 1);
    localparam logic [SYNC_W-1:0] PRBS_LEN = SYNC_W'(PRBS_BITS);
    localparam logic [SYNC_W-1:0] MEM_LEN  = SYNC_W'(MEM_BITS);
    localparam logic [HI_W-1:0]   HI_MAX   = HI_W'(MIN_GATE_CLKS);
    localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(BACKLASH_BITS);
    localparam logic [BB_W-1:0]   BB_MAX   = BB_W'(MIN_BURST_BITS);

    phase_t            phase_q, ph_eff;
    logic [HI_W-1:0]   hi_q;
    logic [GAP_W-1:0]  gapb_q;
    logic [BB_W-1:0]   bb_q, bb_eff;
    logic [SYNC_W-1:0] sync_q, sync_eff, sync_len;
    logic              first_q, first_eff;
    logic              start, timing_ok, in_burst, end_now, take;

    // Burst start decision and the phase/counter view used for this bit.
    always_comb begin
        start      = enable && (phase_q == PH_GAP) && !gate;
        timing_ok  = (hi_q == HI_MAX) && (gapb_q == GAP_MAX);
        ph_eff     = start ? (timing_ok ? PH_SYNC : PH_REJ) : phase_q;
        bb_eff     = start ? '0 : bb_q;
        sync_eff   = start ? '0 : sync_q;
        first_eff  = start ? 1'b1 : first_q;
        sync_len   = mem_pattern ? MEM_LEN : PRBS_LEN;
        in_burst   = (ph_eff == PH_SYNC) || (ph_eff == PH_COUNT);
        end_now    = enable && gate && (ph_eff != PH_GAP);
        take       = enable && !gate && bit_valid;
        count_now  = take && (ph_eff == PH_COUNT);
        resync_now = take && (ph_eff == PH_SYNC) && first_eff;
        commit     = end_now && in_burst && (bb_eff == BB_MAX);
        short_end  = end_now && in_burst && (bb_eff != BB_MAX);
        reject_now = start && !timing_ok;
        pend_clr   = end_now || start;
    end

    // Phase, gap timing and burst length bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_GAP;
            hi_q    <= HI_MAX;
            gapb_q  <= GAP_MAX;
            bb_q    <= '0;
            sync_q  <= '0;
            first_q <= 1'b0;
        end else if (enable) begin
            phase_q <= ph_eff;
            bb_q    <= bb_eff;
            sync_q  <= sync_eff;
            first_q <= first_eff;
            if (gate) begin
                if (ph_eff == PH_GAP) begin
                    if (hi_q != HI_MAX) hi_q <= hi_q + HI_W'(1);
                    if (bit_valid && gapb_q != GAP_MAX) gapb_q <= gapb_q + GAP_W'(1);
                end else begin
                    phase_q <= PH_GAP;
                    hi_q    <= HI_W'(1);
                    gapb_q  <= bit_valid ? GAP_W'(1) : '0;
                end
            end else if (bit_valid && in_burst) begin
                if (bb_eff != BB_MAX) bb_q <= bb_eff + BB_W'(1);
                if (ph_eff == PH_SYNC) begin
                    first_q <= 1'b0;
                    sync_q  <= sync_eff + SYNC_W'(1);
                    if (sync_eff + SYNC_W'(1) == sync_len) phase_q <= PH_COUNT;
                end
            end
        end
    end
endmodule

// File: rtl/bgr_tally.sv
// Error tally: saturating main count, saturating pending burst count with
// commit/discard, and the sticky timing-violation flag. clr wins.
// Assumes inc_direct and commit are never high together.
module bgr_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_direct,
    input  logic             inc_pend,
    input  logic             commit,
    input  logic             pend_clr,
    input  logic             viol_set,
    output logic [CNT_W-1:0] err_count,
    output logic             timing_viol
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_q, pend_q;
    logic [CNT_W:0]   sum;
    logic             viol_q;

    // Width-extended sum used for a saturating commit.
    always_comb sum = {1'b0, cnt_q} + {1'b0, pend_q};

    // Count, pending and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            pend_q <= '0;
            viol_q <= 1'b0;
        end else begin
            if (inc_direct && cnt_q != CMAX) cnt_q <= cnt_q + CNT_W'(1);
            if (commit) cnt_q <= sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
            if (pend_clr) pend_q <= '0;
            else if (inc_pend && pend_q != CMAX) pend_q <= pend_q + CNT_W'(1);
            if (viol_set) viol_q <= 1'b1;
        end
    end

    assign err_count   = cnt_q;
    assign timing_viol = viol_q;
endmodule

// File: rtl/bgr_controller.sv
// Top: burst gating and resync controller. Chooses between the block
// quantizer (gated mode) and the burst phase machine (burst mode), feeds
// the tally, and registers the per-bit outputs.
// Assumes one received bit per clock at most and static mode inputs.
module bgr_controller #(
    parameter int BLOCK_BITS       = 512,
    parameter int PRBS_SYNC_BLOCKS = 3,
    parameter int MEM_SYNC_BLOCKS  = 30,
    parameter int BACKLASH_BITS    = 1536,
    parameter int MIN_BURST_BITS   = 2560,
    parameter int MIN_GATE_CLKS    = 256,
    parameter int CNT_W            = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             burst_mode,
    input  logic             mem_pattern,
    input  logic             gate,
    input  logic             bit_valid,
    input  logic             bit_err,
    output logic             count_en,
    output logic             resync,
    output logic [CNT_W-1:0] err_count,
    output logic             timing_viol
);
    logic gate_eff, count_now, resync_now, commit, short_end, reject_now, pend_clr;
    logic gated_take, en_d, cnt_en_q, resync_q;

    bgr_block_quant #(.BLOCK_BITS(BLOCK_BITS)) u_quant (
        .clk(clk), .rst_n(rst_n), .gate(gate), .bit_valid(bit_valid),
        .gate_eff(gate_eff)
    );

    bgr_burst_fsm #(
        .BLOCK_BITS(BLOCK_BITS), .PRBS_SYNC_BLOCKS(PRBS_SYNC_BLOCKS),
        .MEM_SYNC_BLOCKS(MEM_SYNC_BLOCKS), .BACKLASH_BITS(BACKLASH_BITS),
        .MIN_BURST_BITS(MIN_BURST_BITS), .MIN_GATE_CLKS(MIN_GATE_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(burst_mode), .mem_pattern(mem_pattern),
        .gate(gate), .bit_valid(bit_valid), .count_now(count_now),
        .resync_now(resync_now), .commit(commit), .short_end(short_end),
        .reject_now(reject_now), .pend_clr(pend_clr)
    );

    // Per-mode counting decision for the present bit.
    always_comb begin
        gated_take = !burst_mode && bit_valid && !gate_eff;
        en_d       = burst_mode ? count_now : gated_take;
    end

    bgr_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .inc_direct(gated_take && bit_err), .inc_pend(count_now && bit_err),
        .commit(commit), .pend_clr(pend_clr), .viol_set(reject_now || short_end),
        .err_count(err_count), .timing_viol(timing_viol)
    );

    // Register the per-bit count enable and resync request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q <= 1'b0;
            resync_q <= 1'b0;
        end else begin
            cnt_en_q <= en_d;
            resync_q <= resync_now;
        end
    end

    assign count_en = cnt_en_q;
    assign resync   = resync_q;
endmodule

// File: rtl/bgr_checker.sv
// Checker for bgr_controller: temporal properties over its ports.
// Assumes the mode inputs are held steady while out of reset.
module bgr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             burst_mode,
    input logic             gate,
    input logic             bit_valid,
    input logic             count_en,
    input logic             resync,
    input logic [CNT_W-1:0] err_count,
    input logic             timing_viol
);
    logic past_ok;

    // Marks that a full clock out of reset has been seen.
    always_ff @(posedge clk) past_ok <= rst_n;

    assert_resync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && resync |=> !resync);

    assert_no_count_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(resync && count_en));

    assert_gate_high_uncounted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(burst_mode) && $past(gate) |-> !count_en);

    assert_count_needs_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && count_en |-> $past(bit_valid));

    assert_no_decrease_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clr) |-> err_count >= $past(err_count));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(burst_mode) && !$past(clr) |->
        ({1'b0, err_count} <= {1'b0, $past(err_count)} + 1'b1));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(clr) |-> (err_count == '0) && !timing_viol);

    assert_viol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(timing_viol) && !$past(clr) |-> timing_viol);
endmodule

bind bgr_controller bgr_checker #(.CNT_W(CNT_W)) u_bgr_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .burst_mode(burst_mode), .gate(gate),
    .bit_valid(bit_valid), .count_en(count_en), .resync(resync),
    .err_count(err_count), .timing_viol(timing_viol)
);

// File: tb/test_bgr_controller.sv
module test_bgr_controller;
    localparam int BB = 8, PS = 3, MS = 5, BL = 20, MB = 60, MG = 6, CW = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr = 1'b0, burst_mode = 1'b0, mem_pattern = 1'b0;
    logic gate = 1'b1, bit_valid = 1'b0, bit_err = 1'b0;
    logic count_en, resync, timing_viol;
    logic [CW-1:0] err_count;

    int n_checks = 0, n_errs = 0, cycles = 0;
    int en_seen = 0, rs_seen = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    bgr_controller #(
        .BLOCK_BITS(BB), .PRBS_SYNC_BLOCKS(PS), .MEM_SYNC_BLOCKS(MS),
        .BACKLASH_BITS(BL), .MIN_BURST_BITS(MB), .MIN_GATE_CLKS(MG), .CNT_W(CW)
    ) i_bgr_controller (
        .clk(clk), .rst_n(rst_n), .clr(clr), .burst_mode(burst_mode),
        .mem_pattern(mem_pattern), .gate(gate), .bit_valid(bit_valid),
        .bit_err(bit_err), .count_en(count_en), .resync(resync),
        .err_count(err_count), .timing_viol(timing_viol)
    );

    // Behavioural reference model, advanced on every rising edge.
    int m_ph, m_hi, m_gb, m_bb, m_sync, m_pos, m_pend, m_cnt;
    bit m_first, m_blkg, m_viol, m_en, m_rs;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_hi = MG; m_gb = BL; m_bb = 0; m_sync = 0; m_first = 0;
            m_pend = 0; m_cnt = 0; m_viol = 0; m_en = 0; m_rs = 0; m_pos = 0; m_blkg = 0;
        end else begin
            m_en = 0; m_rs = 0;
            if (!burst_mode) begin
                automatic bit gq = (m_pos == 0) ? gate : m_blkg;
                if (bit_valid && m_pos == 0) m_blkg = gate;
                if (bit_valid && !gq) begin
                    m_en = 1;
                    if (bit_err && m_cnt < MAXC) m_cnt++;
                end
            end else begin
                automatic int ph = m_ph;
                automatic int slen = (mem_pattern ? MS : PS) * BB;
                if (ph == 0 && !gate) begin
                    if (m_hi >= MG && m_gb >= BL) begin
                        ph = 1; m_bb = 0; m_sync = 0; m_first = 1; m_pend = 0;
                    end else begin
                        ph = 3; m_viol = 1;
                    end
                end
                if (gate) begin
                    if (ph == 0) begin
                        if (m_hi < MG) m_hi++;
                        if (bit_valid && m_gb < BL) m_gb++;
                    end else begin
                        if (ph != 3) begin
                            if (m_bb >= MB) m_cnt = (m_cnt + m_pend > MAXC) ? MAXC : m_cnt + m_pend;
                            else m_viol = 1;
                        end
                        m_pend = 0; ph = 0; m_hi = 1; m_gb = bit_valid ? 1 : 0;
                    end
                end else if (bit_valid) begin
                    if (ph == 1) begin
                        if (m_first) m_rs = 1;
                        m_first = 0;
                        if (m_bb < MB) m_bb++;
                        m_sync++;
                        if (m_sync == slen) ph = 2;
                    end else if (ph == 2) begin
                        m_en = 1;
                        if (m_bb < MB) m_bb++;
                        if (bit_err && m_pend < MAXC) m_pend++;
                    end
                end
                m_ph = ph;
            end
            if (bit_valid) m_pos = (m_pos + 1) % BB;
            if (clr) begin m_cnt = 0; m_pend = 0; m_viol = 0; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one clock of stimulus, then compare all outputs to the model.
    task automatic step(input bit g, input bit v, input bit e);
        gate = g; bit_valid = v; bit_err = e;
        @(negedge clk);
        if (count_en) en_seen++;
        if (resync) rs_seen++;
        chk(cur_req, "count_en", int'(count_en), int'(m_en));
        chk(cur_req, "resync", int'(resync), int'(m_rs));
        chk(cur_req, "err_count", int'(err_count), m_cnt);
        chk(cur_req, "timing_viol", int'(timing_viol), int'(m_viol));
    endtask

    task automatic do_reset(input bit bm, input bit mp);
        rst_n = 1'b0; burst_mode = bm; mem_pattern = mp;
        gate = 1'b1; bit_valid = 1'b0; bit_err = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        step(gate, 1'b0, 1'b0);
        clr = 1'b0;
    endtask

    // Burst of n valid bits; errors on every fifth bit past the window.
    task automatic burst(input int n, input int win, output int exp_err);
        exp_err = 0;
        for (int i = 0; i < n; i++) begin
            automatic bit e = (i >= win) && (i % 5 == 0);
            if (e) exp_err++;
            step(1'b0, 1'b1, e);
        end
    endtask

    task automatic gap(input int n, input int vmod);
        for (int i = 0; i < n; i++) step(1'b1, (i % vmod) == 0, 1'b0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_errs++;
            $display("FAIL R1: watchdog expired, actual cycles=%0d expected below %0d", cycles, 100000);
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int ee, c0;
        // R1: reset state
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        chk("R1", "count_en", int'(count_en), 0);
        chk("R1", "resync", int'(resync), 0);
        chk("R1", "err_count", int'(err_count), 0);
        chk("R1", "timing_viol", int'(timing_viol), 0);

        // R3: two whole gated blocks with errors leave the count at zero
        cur_req = "R3";
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 1'b1);
        chk("R3", "err_count after gated blocks", int'(err_count), 0);
        // R2: gate sampled at block start rules the whole block
        cur_req = "R2";
        en_seen = 0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
        chk("R2", "err_count block-quantized", int'(err_count), 8);
        chk("R2", "count_en cycles", en_seen, 8);
        // R2: random gate, valid and error patterns
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 19) == 0) gate = ~gate;
            step(gate, $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0);
        end
        // R5: clear wins over a same-clock increment
        cur_req = "R5";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0);
        clr = 1'b1; step(1'b0, 1'b1, 1'b1); clr = 1'b0;
        chk("R5", "err_count after clr", int'(err_count), 0);
        // R4: saturation
        cur_req = "R4";
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, 1'b1);
        chk("R4", "err_count saturated", int'(err_count), MAXC);

        // Burst mode, generated pattern
        do_reset(1'b1, 1'b0);
        cur_req = "R6";
        gap(4, 1);
        rs_seen = 0; en_seen = 0;
        burst(100, PS * BB, ee);
        chk("R6", "resync pulses", rs_seen, 1);
        chk("R7", "counted bits after window", en_seen, 100 - PS * BB);
        cur_req = "R8";
        step(1'b1, 1'b1, 1'b1);
        chk("R8", "err_count after commit", int'(err_count), ee);
        chk("R8", "timing_viol", int'(timing_viol), 0);
        // R9: short burst
        cur_req = "R9";
        gap(30, 1);
        c0 = int'(err_count);
        burst(30, PS * BB, ee);
        step(1'b1, 1'b1, 1'b0);
        chk("R9", "err_count after short burst", int'(err_count), c0);
        chk("R9", "timing_viol", int'(timing_viol), 1);
        // R11: flag persists through a later good burst
        cur_req = "R11";
        gap(30, 1);
        burst(70, PS * BB, ee);
        gap(30, 1);
        chk("R11", "timing_viol sticky", int'(timing_viol), 1);
        pulse_clr();
        chk("R11", "timing_viol after clr", int'(timing_viol), 0);
        // R10: short gate pulse
        cur_req = "R10";
        burst(70, PS * BB, ee);
        gap(3, 1);
        c0 = int'(err_count); rs_seen = 0; en_seen = 0;
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1);
        chk("R10", "resync on refused burst", rs_seen, 0);
        chk("R10", "counted bits on refused burst", en_seen, 0);
        step(1'b1, 1'b1, 1'b0);
        chk("R10", "err_count after refused burst", int'(err_count), c0);
        chk("R10", "timing_viol short pulse", int'(timing_viol), 1);
        // R10: backlash not elapsed (enough clocks, too few bits)
        gap(30, 1);
        pulse_clr();
        burst(70, PS * BB, ee);
        gap(12, 4);
        rs_seen = 0;
        burst(70, PS * BB, ee);
        step(1'b1, 1'b0, 1'b0);
        chk("R10", "resync during backlash", rs_seen, 0);
        chk("R10", "timing_viol backlash", int'(timing_viol), 1);
        // R8: commit saturates
        cur_req = "R8";
        gap(30, 1);
        pulse_clr();
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 100; i++) step(1'b0, 1'b1, i >= PS * BB);
            gap(30, 1);
        end
        chk("R8", "err_count saturating commit", int'(err_count), MAXC);

        // Burst mode, memory pattern window
        do_reset(1'b1, 1'b1);
        cur_req = "R7";
        gap(4, 1);
        rs_seen = 0; en_seen = 0;
        burst(100, MS * BB, ee);
        step(1'b1, 1'b1, 1'b0);
        chk("R7", "counted bits memory window", en_seen, 100 - MS * BB);
        chk("R6", "resync pulses memory", rs_seen, 1);
        chk("R8", "err_count memory burst", int'(err_count), ee);

        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule